// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port for a processor bus. A transmitter and a receiver share one bit-rate generator. Software sets the rate, the character length (5 to 8 bits), parity (none, even or odd) and the stop period (1, 1.5 or 2 bit times) through a small register interface. Each character travels as its own frame: a low start bit, the data bits least-significant first, an optional parity bit, and a high stop period.

The rate generator produces one tick every `divisor + 1` clocks. Each bit lasts 16 ticks, so a 1.5-bit stop period lasts 24 ticks. The receiver watches the line on every tick. It confirms a start bit at its middle and samples every later bit at its middle. One character is buffered in each direction. Status flags report whether the transmitter can accept a character, whether a received character is waiting, and whether a character carried a parity error, a framing error or overran a character that had not been read.

Register map (2-bit address): 0 = character (a write sends, a read fetches the received character); 1 = format; 2 = status (read only); 3 = divisor.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the status reads 0x01, the format reads 0x03, the divisor reads the RESET_DIV parameter and `txd` is high.
- R2: A rate tick occurs every `divisor + 1` clocks and each bit lasts 16 ticks. Writing the divisor restarts the tick count at zero.
- R3: A frame is one low start bit, then `format[1:0] + 5` data bits sent least-significant first, then the parity bit when `format[2]` is 1, then the stop period at high level. Bits of the written byte above the character length are not sent.
- R4: The parity bit makes the count of ones over the data bits and the parity bit even when `format[3]` is 0, and odd when it is 1.
- R5: The stop period lasts 16, 24 or 32 ticks for `format[5:4]` = 0, 1 or 2/3. It must pass before status bit 0 (transmitter empty) returns to 1.
- R6: Status bit 0 clears in the clock after a character write is accepted. A character write made while status bit 0 is 0 is ignored.
- R7: The receiver confirms a start bit only when the line is still low 8 ticks after it saw the falling edge. A shorter low pulse leaves status bit 1 at 0.
- R8: When a frame completes, status bit 1 (character ready) is set. The character reads back right-aligned, with the bits above the character length at zero.
- R9: Status bit 2 reports a parity mismatch (only when parity is on). Status bit 3 reports a stop bit sampled low.
- R10: Status bit 4 (overrun) is set when a frame completes while bit 1 is still set. The newer character replaces the older one. A read of address 0 clears status bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a read of address 0 clears the receive flags |
| regWrData | input | DIV_W | Write data |
| regRdData | output | DIV_W | Read data, combinational on `regAddr` |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
Register reads are combinational, so the bench samples read data in the same cycle it puts the address on the bus. Status bit 0 is due one clock after an accepted write. The bench's reference model keeps its own tick counter and a per-tick queue of line levels, and updates it at the same clock edge as the design. It compares `txd` at every falling clock edge, so each bit boundary is checked in the exact cycle it is due: one clock after the tick that ends the previous bit. Receive results depend on a two-flop synchronizer and tick phase, so they land somewhere within a bit time. The bench therefore reads status and data only once a full extra bit time has passed after each driven frame.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int CHAR_MAX = 8;
  localparam int IDX_W = $clog2(CHAR_MAX);

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic             txStart;
    logic             txShift;
    phase_t           txPhase;
    logic             rxBegin;
    logic             rxSample;
    logic             rxParSample;
    logic             rxDone;
    logic [IDX_W-1:0] rxIdx;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic       tick;
    logic       txPending;
    logic [1:0] lenCode;
    logic       parEn;
    logic [1:0] stopCode;
    logic       rxLine;
  } view_t;

  function automatic logic [CHAR_MAX-1:0] lenMask(input logic [1:0] code);
    return {CHAR_MAX{1'b1}} >> (3'd3 - {1'b0, code});
  endfunction
endpackage

// File: rtl/xcvr_baud.sv
module xcvr_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == divisor);

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  view_t   v,
  output strobe_t s
);
  localparam int TICK_W = $clog2(OVERSAMPLE * 2);
  localparam logic [TICK_W-1:0] LAST   = TICK_W'(OVERSAMPLE - 1);
  localparam logic [TICK_W-1:0] MID    = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] STOP15 = TICK_W'(OVERSAMPLE * 3 / 2 - 1);
  localparam logic [TICK_W-1:0] STOP2  = TICK_W'(OVERSAMPLE * 2 - 1);

  phase_t txPh, rxPh;
  logic [TICK_W-1:0] txTicks, rxTicks, stopLast;
  logic [IDX_W-1:0] txBits, rxBits, lastBit;
  logic txBitEnd, rxBitEnd, rxMid;

  assign lastBit  = IDX_W'({1'b0, v.lenCode} + 3'd4);
  assign txBitEnd = (txTicks == LAST);
  assign rxBitEnd = (rxTicks == LAST);
  assign rxMid    = (rxTicks == MID);

  always_comb begin
    case (v.stopCode)
      2'd0:    stopLast = LAST;
      2'd1:    stopLast = STOP15;
      default: stopLast = STOP2;
    endcase
  end

  // transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPh <= PH_IDLE;
      txTicks <= '0;
      txBits <= '0;
    end else if (v.tick) begin
      case (txPh)
        PH_IDLE: if (v.txPending) begin
          txPh <= PH_START;
          txTicks <= '0;
        end
        PH_START: if (txBitEnd) begin
          txPh <= PH_DATA;
          txTicks <= '0;
          txBits <= '0;
        end else txTicks <= txTicks + 1'b1;
        PH_DATA: if (txBitEnd) begin
          txTicks <= '0;
          if (txBits == lastBit) txPh <= v.parEn ? PH_PARITY : PH_STOP;
          else txBits <= txBits + 1'b1;
        end else txTicks <= txTicks + 1'b1;
        PH_PARITY: if (txBitEnd) begin
          txPh <= PH_STOP;
          txTicks <= '0;
        end else txTicks <= txTicks + 1'b1;
        PH_STOP: if (txTicks == stopLast) begin
          txPh <= PH_IDLE;
          txTicks <= '0;
        end else txTicks <= txTicks + 1'b1;
        default: txPh <= PH_IDLE;
      endcase
    end
  end

  // receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPh <= PH_IDLE;
      rxTicks <= '0;
      rxBits <= '0;
    end else if (v.tick) begin
      case (rxPh)
        PH_IDLE: if (!v.rxLine) begin
          rxPh <= PH_START;
          rxTicks <= '0;
        end
        PH_START: if (rxMid) begin
          rxTicks <= '0;
          rxBits <= '0;
          rxPh <= v.rxLine ? PH_IDLE : PH_DATA;
        end else rxTicks <= rxTicks + 1'b1;
        PH_DATA: if (rxBitEnd) begin
          rxTicks <= '0;
          if (rxBits == lastBit) rxPh <= v.parEn ? PH_PARITY : PH_STOP;
          else rxBits <= rxBits + 1'b1;
        end else rxTicks <= rxTicks + 1'b1;
        PH_PARITY: if (rxBitEnd) begin
          rxPh <= PH_STOP;
          rxTicks <= '0;
        end else rxTicks <= rxTicks + 1'b1;
        PH_STOP: if (rxBitEnd) begin
          rxPh <= PH_IDLE;
          rxTicks <= '0;
        end else rxTicks <= rxTicks + 1'b1;
        default: rxPh <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    s = '0;
    s.txPhase     = txPh;
    s.txStart     = v.tick && (txPh == PH_IDLE) && v.txPending;
    s.txShift     = v.tick && (txPh == PH_DATA) && txBitEnd;
    s.rxBegin     = v.tick && (rxPh == PH_IDLE) && !v.rxLine;
    s.rxSample    = v.tick && (rxPh == PH_DATA) && rxBitEnd;
    s.rxParSample = v.tick && (rxPh == PH_PARITY) && rxBitEnd;
    s.rxDone      = v.tick && (rxPh == PH_STOP) && rxBitEnd;
    s.rxIdx       = rxBits;
  end
endmodule

// File: rtl/xcvr_dpath.sv
module xcvr_dpath
  import xcvr_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [DIV_W-1:0] regWrData,
  output logic [DIV_W-1:0] regRdData,
  output logic             txd,
  input  logic             rxd,
  input  logic             tick,
  input  strobe_t          s,
  output view_t            v,
  output logic             baudRestart,
  output logic [DIV_W-1:0] divisor,
  output logic [4:0]       statusVec
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_FMT  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  logic [5:0] fmt;
  logic [DIV_W-1:0] divReg;
  logic [CHAR_MAX-1:0] hold, txSh, rxBuf, rxData, mask;
  logic pending, txPar, rxPar, rxReady, parErr, frameErr, overrun;
  logic [1:0] rxSync;
  logic wrData, wrFmt, wrDiv, rdData, txEmpty;

  assign wrData  = regWr && (regAddr == A_DATA);
  assign wrFmt   = regWr && (regAddr == A_FMT);
  assign wrDiv   = regWr && (regAddr == A_DIV);
  assign rdData  = regRd && (regAddr == A_DATA);
  assign mask    = lenMask(fmt[1:0]);
  assign txEmpty = !pending && (s.txPhase == PH_IDLE);

  assign baudRestart = wrDiv;
  assign divisor     = divReg;
  assign statusVec   = {overrun, frameErr, parErr, rxReady, txEmpty};

  assign v.tick      = tick;
  assign v.txPending = pending;
  assign v.lenCode   = fmt[1:0];
  assign v.parEn     = fmt[2];
  assign v.stopCode  = fmt[5:4];
  assign v.rxLine    = rxSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmt <= 6'h03;
      divReg <= DIV_W'(RESET_DIV);
      hold <= '0;
      pending <= 1'b0;
      txSh <= '0;
      txPar <= 1'b1;
      rxSync <= 2'b11;
      rxBuf <= '0;
      rxPar <= 1'b0;
      rxData <= '0;
      rxReady <= 1'b0;
      parErr <= 1'b0;
      frameErr <= 1'b0;
      overrun <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (wrFmt) fmt <= regWrData[5:0];
      if (wrDiv) divReg <= regWrData;
      if (wrData && txEmpty) begin
        hold <= regWrData[CHAR_MAX-1:0];
        pending <= 1'b1;
      end
      if (s.txStart) begin
        pending <= 1'b0;
        txSh <= hold & mask;
        txPar <= (^(hold & mask)) ^ fmt[3];
      end else if (s.txShift) begin
        txSh <= txSh >> 1;
      end
      if (s.rxBegin) rxBuf <= '0;
      if (s.rxSample) rxBuf[s.rxIdx] <= rxSync[1];
      if (s.rxParSample) rxPar <= rxSync[1];
      if (rdData) begin
        rxReady <= 1'b0;
        parErr <= 1'b0;
        frameErr <= 1'b0;
        overrun <= 1'b0;
      end
      if (s.rxDone) begin
        rxData <= rxBuf;
        rxReady <= 1'b1;
        parErr <= fmt[2] && (((^rxBuf) ^ rxPar) != fmt[3]);
        frameErr <= !rxSync[1];
        if (rxReady && !rdData) overrun <= 1'b1;
      end
    end
  end

  always_comb begin
    case (s.txPhase)
      PH_START:  txd = 1'b0;
      PH_DATA:   txd = txSh[0];
      PH_PARITY: txd = txPar;
      default:   txd = 1'b1;
    endcase
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_DATA: regRdData[CHAR_MAX-1:0] = rxData;
      A_FMT:  regRdData[5:0] = fmt;
      A_STAT: regRdData[4:0] = statusVec;
      default: regRdData = divReg;
    endcase
  end
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import xcvr_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVERSAMPLE = 16,
  parameter int RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [DIV_W-1:0] regWrData,
  output logic [DIV_W-1:0] regRdData,
  output logic             txd,
  input  logic             rxd
);
  strobe_t strb;
  view_t view;
  logic tick, baudRestart;
  logic [DIV_W-1:0] divisor;
  logic [4:0] statusVec;

  xcvr_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .restart(baudRestart), .divisor(divisor), .tick(tick)
  );

  xcvr_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .v(view), .s(strb)
  );

  xcvr_dpath #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) u_dpath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .txd(txd), .rxd(rxd),
    .tick(tick), .s(strb), .v(view), .baudRestart(baudRestart),
    .divisor(divisor), .statusVec(statusVec)
  );
endmodule

// File: rtl/serial_xcvr_chk.sv
module serial_xcvr_chk
  import xcvr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txd,
  input logic       regWr,
  input logic [1:0] regAddr,
  input strobe_t    strb,
  input logic       tick,
  input logic [4:0] statusVec
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPhase == PH_IDLE) |-> txd); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPhase == PH_START) |-> !txd); // R3
  AST_TX_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txStart || strb.txShift) |-> tick); // R2
  AST_TX_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txStart, strb.txShift})); // R3
  AST_RX_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxDone |-> tick); // R7
  AST_EMPTY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd0 && statusVec[0]) |=> !statusVec[0]); // R6
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxDone |=> statusVec[1]); // R8
  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[4]) |-> $past(statusVec[1])); // R10
endmodule

bind serial_xcvr serial_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .txd(txd), .regWr(regWr), .regAddr(regAddr),
  .strb(strb), .tick(tick), .statusVec(statusVec)
);

// File: tb/serial_xcvr_tb.sv
module serial_xcvr_tb;
  localparam int RST_DIV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic txd;
  logic rxd = 1'b1;

  int checks = 0, fails = 0, lineFails = 0, curDiv = RST_DIV;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_xcvr #(.DIV_W(16), .OVERSAMPLE(16), .RESET_DIV(RST_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .txd(txd), .rxd(rxd)
  );

  // ---------------- behavioural reference model of the transmit side
  int mBaud, mDiv;
  bit mPending, mBusy, mTxd, tk, emp;
  logic [7:0] mHold;
  logic [5:0] mFmt;
  bit q[$];

  task automatic pushLevel(input bit lvl, input int n);
    for (int i = 0; i < n; i++) q.push_back(lvl);
  endtask

  task automatic buildFrame();
    int n;
    bit p;
    n = int'(mFmt[1:0]) + 5;
    p = mFmt[3];
    pushLevel(1'b0, 16);
    for (int i = 0; i < n; i++) begin
      pushLevel(mHold[i], 16);
      p = p ^ mHold[i];
    end
    if (mFmt[2]) pushLevel(p, 16);
    case (mFmt[5:4])
      2'd0: pushLevel(1'b1, 16);
      2'd1: pushLevel(1'b1, 24);
      default: pushLevel(1'b1, 32);
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBaud = 0; mDiv = RST_DIV; mPending = 0; mBusy = 0;
      mFmt = 6'h03; mTxd = 1; mHold = '0; q.delete();
    end else begin
      tk = (mBaud == mDiv);
      emp = !mPending && !mBusy;
      if (regWr && regAddr == 2'd3) mBaud = 0;
      else if (tk) mBaud = 0;
      else mBaud++;
      if (tk) begin
        if (q.size() > 0) mTxd = q.pop_front();
        else if (mBusy) begin mBusy = 0; mTxd = 1; end
        else if (mPending) begin
          buildFrame();
          mTxd = q.pop_front();
          mBusy = 1;
          mPending = 0;
        end
      end
      if (regWr && regAddr == 2'd0 && emp) begin mPending = 1; mHold = regWrData[7:0]; end
      if (regWr && regAddr == 2'd1) mFmt = regWrData[5:0];
      if (regWr && regAddr == 2'd3) mDiv = int'(regWrData);
    end
  end

  // line compare every clock: R2 R3 R4 R5 R6
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (txd !== mTxd) begin
        fails++;
        lineFails++;
        if (lineFails <= 10)
          $display("FAIL R2/R3/R4/R5 txd at %0t actual=%b expected=%b", $time, txd, mTxd);
      end
    end
  end

  // ---------------- helpers
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    if (a == 2'd3) curDiv = int'(d);
  endtask

  task automatic regRead(input logic [1:0] a, output int val);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 val = int'(regRdData);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitTxEmpty();
    int st;
    for (int i = 0; i < 8000; i++) begin
      regRead(2'd2, st);
      if (st[0]) return;
    end
  endtask

  task automatic drive(input bit lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic rxFrame(input logic [7:0] val, input int n, input bit parEn,
                         input bit parOdd, input bit flipPar, input bit badStop);
    int bitClk;
    bit p;
    bitClk = 16 * (curDiv + 1);
    p = parOdd ^ flipPar;
    @(negedge clk);
    drive(1'b0, bitClk);
    for (int i = 0; i < n; i++) begin
      drive(val[i], bitClk);
      p = p ^ val[i];
    end
    if (parEn) drive(p, bitClk);
    if (badStop) drive(1'b0, 24);
    drive(1'b1, 3 * bitClk);
  endtask

  // ---------------- stimulus
  initial begin
    int v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd2, v); check("R1 status", v, 32'h01);
    regRead(2'd1, v); check("R1 format", v, 32'h03);
    regRead(2'd3, v); check("R1 divisor", v, RST_DIV);
    check("R1 txd idle", int'(txd), 1);

    // R2 divisor at 2, 8N1 frame
    regWrite(2'd3, 16'd2);
    regWrite(2'd0, 16'h00A5);
    regRead(2'd2, v); check("R6 empty clears after write", v & 1, 0);
    repeat (50) @(negedge clk);
    regWrite(2'd0, 16'h0077); // R6 ignored while busy; line model catches a resend
    waitTxEmpty();
    repeat (200) @(negedge clk);
    regRead(2'd2, v); check("R6 no queued frame after busy write", v & 1, 1);

    // R3 R4 R5: 5 bits even parity, 1.5 stop; upper bits masked
    regWrite(2'd3, 16'd1);
    regWrite(2'd1, 16'h0014);
    regWrite(2'd0, 16'h00F3);
    waitTxEmpty();
    // R4 odd parity, 7 bits, 2 stop
    regWrite(2'd1, 16'h002E);
    regWrite(2'd0, 16'h0041);
    waitTxEmpty();
    // R5 back-to-back 6-bit, 1.5 stop
    regWrite(2'd1, 16'h0011);
    regWrite(2'd0, 16'h002C);
    waitTxEmpty();
    regWrite(2'd0, 16'h003F);
    waitTxEmpty();
    repeat (100) @(negedge clk);

    // receive side at divisor 1
    regWrite(2'd1, 16'h0003);
    rxFrame(8'h5A, 8, 0, 0, 0, 0);
    regRead(2'd2, v); check("R8 ready 8N1", v, 32'h03);
    regRead(2'd0, v); check("R8 data 8N1", v, 32'h5A);
    regRead(2'd2, v); check("R10 read clears", v, 32'h01);

    regWrite(2'd1, 16'h0004); // 5 bits even parity
    rxFrame(8'h15, 5, 1, 0, 0, 0);
    regRead(2'd2, v); check("R9 no parity error even", v, 32'h03);
    regRead(2'd0, v); check("R8 5-bit right aligned", v, 32'h15);
    rxFrame(8'h15, 5, 1, 0, 1, 0);
    regRead(2'd2, v); check("R9 parity error flagged", v, 32'h07);
    regRead(2'd0, v);
    regRead(2'd2, v); check("R10 read clears parity error", v, 32'h01);

    regWrite(2'd1, 16'h000E); // 7 bits odd parity
    rxFrame(8'h41, 7, 1, 1, 0, 0);
    regRead(2'd2, v); check("R4 odd parity accepted", v, 32'h03);
    regRead(2'd0, v); check("R8 7-bit data", v, 32'h41);

    regWrite(2'd1, 16'h0003);
    rxFrame(8'h0F, 8, 0, 0, 0, 1);
    regRead(2'd2, v); check("R9 framing error flagged", v, 32'h0B);
    regRead(2'd0, v); check("R9 framing data", v, 32'h0F);
    regRead(2'd2, v); check("R10 read clears framing error", v, 32'h01);

    // R7 short low pulse rejected
    @(negedge clk);
    drive(1'b0, 8);
    drive(1'b1, 96);
    regRead(2'd2, v); check("R7 glitch rejected", v, 32'h01);

    // R10 overrun
    rxFrame(8'h11, 8, 0, 0, 0, 0);
    rxFrame(8'h22, 8, 0, 0, 0, 0);
    regRead(2'd2, v); check("R10 overrun set", v, 32'h13);
    regRead(2'd0, v); check("R10 newer data kept", v, 32'h22);
    regRead(2'd2, v); check("R10 overrun cleared", v, 32'h01);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule